// File: doc/BRIEF.md
# Fractional Baud Tick Prescaler

This block divides a fast reference clock down to the 16x oversampling tick that a UART uses. The divisor is an integer part plus a fraction in eighths. Each tick period lasts either the integer part or one clock more. An accumulator decides which periods get the extra clock, so over any eight consecutive periods the average length equals the requested divisor exactly. With a 48 MHz reference, a divisor d gives a tick rate of 48 MHz / d, which is a baud rate of 3 Mbaud / d.

Two integer codes below the normal range pick fixed fast rates. Integer 0 gives a tick on every clock, which is 3 Mbaud. Integer 1 gives an average period of 1.5 clocks, which is 2 Mbaud. Any fraction written with these codes is ignored.

A new divisor is written into a shadow register. It is adopted at the next tick, so a period that is already running always finishes at its old length. The same tick also paces a parallel output port. A byte written into a one-entry staging register is driven onto the port on a tick when that output is enabled.

Top module: `baud_tick_prescaler`

## Requirements
- R1: After reset the staged-byte flag is 0, the port is 0 and the divisor is the `RESET_INT` parameter (default 26) with fraction 0. The tick is high in the first cycle after reset is released, and the next tick comes exactly `RESET_INT` cycles later.
- R2: The tick is high for one cycle per period. With an integer part n of 2 or more and fraction 0, consecutive ticks are exactly n cycles apart.
- R3: The integer field is 14 bits wide. Every value from 2 to 16383 is a plain divisor, including the largest one.
- R4: With integer n (2 or more) and fraction f (3 bits, in eighths, 0 to 7), the k-th period after adoption (k = 1, 2, ...) lasts n+1 cycles when floor(k*f/8) > floor((k-1)*f/8), and n cycles otherwise. Any eight consecutive periods therefore total 8n+f cycles.
- R5: Integer code 0 makes every period 1 cycle long (tick held high), whatever the fraction.
- R6: Integer code 1 makes the periods alternate 1, 2, 1, 2, ... starting with 1 after adoption, whatever the fraction.
- R7: A divisor write takes effect at the first tick in a cycle after the write. The period in progress when the write arrives keeps its old length.
- R8: When the parallel output is enabled and a byte is staged, the port shows that byte from the cycle after a tick, and the staged flag clears in that same cycle. At no other time does the port change.
- R9: While the parallel output is disabled, the port holds its value across ticks and a staged byte stays staged.
- R10: A byte written while another is still staged replaces it. Only the latest byte reaches the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divWr | input | 1 | Write strobe for the divisor shadow |
| divInt | input | 14 | Integer part of the divisor (0 and 1 are the fast codes) |
| divFrac | input | 3 | Fractional part in eighths |
| bbEn | input | 1 | Enables tick-paced updates of the parallel port |
| bbWr | input | 1 | Stages bbData for the port |
| bbData | input | 8 | Byte to stage |
| tick | output | 1 | Oversampling tick, one cycle per period |
| bbPort | output | 8 | Parallel output port |
| bbBusy | output | 1 | A staged byte is waiting for a tick |

## Verification
The bench measures the gap between ticks, period by period, and compares each gap with the floor formula. A design that spread the fraction wrongly would show the wrong pattern of long and short periods, even when its eight-period total is right. The two fast codes are sent with nonzero fractions. A design that honoured those fractions would show periods longer than 1 for code 0, or something other than a 1, 2 alternation for code 1. A write in the middle of a long period checks that the old length still finishes; a design that adopted the divisor at once would tick early. The parallel port is checked across ticks with output disabled, and with two bytes staged back to back. A design that leaked data, or kept the first byte, would put the wrong value on the port.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int DIV_INT_W  = 14;
  localparam int DIV_FRAC_W = 3;
  localparam int BB_W       = 8;

  typedef struct packed {
    logic [DIV_INT_W-1:0] periodInt;
    logic                 stretch;
  } periodStrobe_t;
endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int RESET_INT = 26
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  divWr,
  input  logic [DIV_INT_W-1:0]  divInt,
  input  logic [DIV_FRAC_W-1:0] divFrac,
  input  logic                  tick,
  output periodStrobe_t         strobes
);
  localparam logic [DIV_FRAC_W-1:0] HALF_FRAC = DIV_FRAC_W'(1 << (DIV_FRAC_W - 1));

  logic [DIV_INT_W-1:0]  actInt, shInt, selInt;
  logic [DIV_FRAC_W-1:0] actFrac, shFrac, selFrac, acc, accBase;
  logic                  shValid;
  logic [DIV_FRAC_W:0]   accSum;

  always_comb begin
    if (shValid) begin
      accBase = '0;
      if (shInt == '0) begin
        selInt  = DIV_INT_W'(1);
        selFrac = '0;
      end else if (shInt == DIV_INT_W'(1)) begin
        selInt  = DIV_INT_W'(1);
        selFrac = HALF_FRAC;
      end else begin
        selInt  = shInt;
        selFrac = shFrac;
      end
    end else begin
      accBase = acc;
      selInt  = actInt;
      selFrac = actFrac;
    end
    accSum            = {1'b0, accBase} + {1'b0, selFrac};
    strobes.periodInt = selInt;
    strobes.stretch   = accSum[DIV_FRAC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actInt  <= DIV_INT_W'(RESET_INT);
      actFrac <= '0;
      acc     <= '0;
      shInt   <= '0;
      shFrac  <= '0;
      shValid <= 1'b0;
    end else begin
      if (tick) begin
        actInt  <= selInt;
        actFrac <= selFrac;
        acc     <= accSum[DIV_FRAC_W-1:0];
        shValid <= 1'b0;
      end
      if (divWr) begin
        shInt   <= divInt;
        shFrac  <= divFrac;
        shValid <= 1'b1;
      end
    end
  end

  // R4: a zero fraction never lengthens a period
  p_no_stretch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selFrac == '0) |-> !strobes.stretch);

  // R7: the shadow is consumed at the first tick after the write
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && shValid && !divWr) |=> !shValid);

  // R5: code 0 turns into a one-cycle period with no fraction
  p_code_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && shValid && shInt == '0 && !divWr) |=> (actInt == DIV_INT_W'(1) && actFrac == '0));

  // R6: code 1 turns into a divisor of one and a half
  p_code_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && shValid && shInt == DIV_INT_W'(1)) |=> (actInt == DIV_INT_W'(1) && actFrac == HALF_FRAC));
endmodule

// File: rtl/baud_tick_datapath.sv
module baud_tick_datapath
  import baud_tick_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  periodStrobe_t   strobes,
  input  logic            bbEn,
  input  logic            bbWr,
  input  logic [BB_W-1:0] bbData,
  output logic            tick,
  output logic [BB_W-1:0] bbPort,
  output logic            bbBusy
);
  localparam int CNT_W = DIV_INT_W + 1;

  logic [CNT_W-1:0] cnt, reloadLen;
  logic [BB_W-1:0]  bbHold;
  logic             bbPending;

  assign tick      = (cnt == '0);
  assign reloadLen = {1'b0, strobes.periodInt} + CNT_W'(strobes.stretch) - CNT_W'(1);
  assign bbBusy    = bbPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (tick) cnt <= reloadLen;
    else cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bbPort    <= '0;
      bbHold    <= '0;
      bbPending <= 1'b0;
    end else begin
      if (tick && bbEn && bbPending) begin
        bbPort    <= bbHold;
        bbPending <= 1'b0;
      end
      if (bbWr) begin
        bbHold    <= bbData;
        bbPending <= 1'b1;
      end
    end
  end

  // R8: the port moves only in the cycle after a tick
  p_port_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(bbPort));

  // R9: a disabled port never changes
  p_port_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bbEn |=> $stable(bbPort));

  // R3: the counter stays within the 14-bit divisor range
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(1 << DIV_INT_W));
endmodule

// File: rtl/baud_tick_prescaler.sv
module baud_tick_prescaler
  import baud_tick_pkg::*;
#(
  parameter int RESET_INT = 26
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  divWr,
  input  logic [DIV_INT_W-1:0]  divInt,
  input  logic [DIV_FRAC_W-1:0] divFrac,
  input  logic                  bbEn,
  input  logic                  bbWr,
  input  logic [BB_W-1:0]       bbData,
  output logic                  tick,
  output logic [BB_W-1:0]       bbPort,
  output logic                  bbBusy
);
  periodStrobe_t strobes;

  baud_tick_ctrl #(.RESET_INT(RESET_INT)) i_ctrl (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divInt(divInt),
    .divFrac(divFrac), .tick(tick), .strobes(strobes)
  );

  baud_tick_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bbEn(bbEn), .bbWr(bbWr),
    .bbData(bbData), .tick(tick), .bbPort(bbPort), .bbBusy(bbBusy)
  );
endmodule

// File: tb/test_baud_tick_prescaler.sv
module test_baud_tick_prescaler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        divWr = 1'b0;
  logic [13:0] divInt = '0;
  logic [2:0]  divFrac = '0;
  logic        bbEn = 1'b0;
  logic        bbWr = 1'b0;
  logic [7:0]  bbData = '0;
  logic        tick;
  logic [7:0]  bbPort;
  logic        bbBusy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  baud_tick_prescaler i_baud_tick_prescaler (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divInt(divInt), .divFrac(divFrac),
    .bbEn(bbEn), .bbWr(bbWr), .bbData(bbData), .tick(tick), .bbPort(bbPort),
    .bbBusy(bbBusy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int expPeriod(int n, int f, int k);
    int en = n;
    int ef = f;
    if (n == 0) return 1;
    if (n == 1) begin en = 1; ef = 4; end
    return en + (((k * ef) / 8 > ((k - 1) * ef) / 8) ? 1 : 0);
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitTick(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!tick && c < 40000);
  endtask

  task automatic writeDiv(int n, int f);
    divWr   = 1'b1;
    divInt  = 14'(n);
    divFrac = 3'(f);
    @(negedge clk);
    divWr = 1'b0;
  endtask

  task automatic setAndAdopt(int n, int f);
    int c;
    writeDiv(n, f);
    if (!tick) waitTick(c);
  endtask

  task automatic measure(int n, int f, int count, string tag);
    int c;
    for (int k = 1; k <= count; k++) begin
      waitTick(c);
      chk(c, expPeriod(n, f, k), tag);
    end
  endtask

  task automatic stageByte(logic [7:0] d);
    bbWr   = 1'b1;
    bbData = d;
    @(negedge clk);
    bbWr = 1'b0;
  endtask

  initial begin
    int c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(tick, 1, "R1 tick after reset");
    chk(bbPort, 0, "R1 port after reset");
    chk(bbBusy, 0, "R1 staged flag after reset");
    waitTick(c);
    chk(c, 26, "R1 reset divisor period");

    // R2 integer divisors
    setAndAdopt(7, 0);
    measure(7, 0, 4, "R2 period n=7");
    setAndAdopt(2, 0);
    measure(2, 0, 4, "R2 period n=2");

    // R4 fractions
    for (int f = 1; f < 8; f++) begin
      setAndAdopt(5, f);
      measure(5, f, 9, "R4 fractional period");
    end

    // R5 code 0 with a fraction
    setAndAdopt(0, 5);
    measure(0, 5, 6, "R5 code zero period");
    // R6 code 1 with a fraction
    setAndAdopt(1, 7);
    measure(1, 7, 6, "R6 code one period");

    // R7 write in mid period
    setAndAdopt(40, 0);
    repeat (4) @(negedge clk);
    writeDiv(3, 0);
    chk(tick, 0, "R7 no early tick");
    waitTick(c);
    chk(c, 35, "R7 old period completes");
    measure(3, 0, 3, "R7 new period");

    // R8 port update on tick
    setAndAdopt(6, 0);
    bbEn = 1'b1;
    @(negedge clk);
    stageByte(8'hA5);
    chk(bbBusy, 1, "R8 staged flag set");
    chk(bbPort, 0, "R8 port before tick");
    while (!tick) @(negedge clk);
    chk(bbPort, 0, "R8 port during tick cycle");
    @(negedge clk);
    chk(bbPort, 8'hA5, "R8 port after tick");
    chk(bbBusy, 0, "R8 staged flag cleared");
    for (int i = 0; i < 4; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      stageByte(d);
      while (!tick) @(negedge clk);
      @(negedge clk);
      chk(bbPort, d, "R8 byte sequence");
    end

    // R9 and R10 disabled port, replacement
    bbEn = 1'b0;
    stageByte(8'h3C);
    stageByte(8'hC3);
    waitTick(c);
    @(negedge clk);
    waitTick(c);
    @(negedge clk);
    chk(bbBusy, 1, "R9 byte stays staged");
    chk(int'(bbPort) == 8'h3C || int'(bbPort) == 8'hC3, 0, "R9 port holds");
    bbEn = 1'b1;
    while (!tick) @(negedge clk);
    @(negedge clk);
    chk(bbPort, 8'hC3, "R10 latest byte wins");
    bbEn = 1'b0;

    // random divisors
    for (int i = 0; i < 20; i++) begin
      int n;
      int f;
      n = 2 + int'($urandom_range(198));
      f = int'($urandom_range(7));
      if (i == 5) n = 0;
      if (i == 11) n = 1;
      setAndAdopt(n, f);
      measure(n, f, 9, "R4 random divisor");
    end

    // R3 largest divisor
    setAndAdopt(16383, 7);
    measure(16383, 7, 2, "R3 largest divisor");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule